// File: doc/BRIEF.md
# Debug Event Pin Controller

This block sits inside an on-chip debug unit and governs three bidirectional debug event pins. A 6-bit mode register gives each pin a 2-bit code. The code makes the pin do one of four things. It can drive a level that flips each time its address comparator reports a match. Pin 1 alone can instead drive a debug-acknowledge level. The pin can also be sampled as an input, which then widens a comparator or counter enable, raises a one-cycle event and, on pin 0 only, requests debug entry. Codes that a pin does not define leave the pin as an inert input.

Pin inputs cross into the clock domain through a synchronizer of `SYNC_STAGES` flops. The synchronizer has no reset, so it samples during reset. Pin 0 comes out of reset in debug-request mode. A pin 0 held high through reset therefore has the core's debug request already raised when reset lifts, before any instruction is dispatched. While that request is active and the core is stopped or waiting, a wake request is produced as well.

Top module: `evpin_ctrl`

## Requirements
- R1: Reset state: the mode register holds pin 2 code 00, pin 1 code 00, pin 0 code 11. All toggle flops are 0. pad_oe is 3'b110 and pad_out is 3'b000.
- R2: A write with cfg_we high loads cfg_wdata on the next clock edge. Bits [5:4] hold the pin 2 code, bits [3:2] the pin 1 code and bits [1:0] the pin 0 code.
- R3: Code 00 on any pin sets that pin's pad_oe to 1. Its pad_out then inverts on the clock edge that samples its cmp_hit bit high, and holds its value otherwise.
- R4: Pin 1 code 01 sets pad_oe[1] to 1. pad_out[1] takes the value core_in_debug had at the previous clock edge. It holds unchanged at every edge where core_single_step is 1.
- R5: The input codes are pin 2 code 11, pin 1 code 11, and pin 0 codes 10 and 11. In an input code, a pin that is synchronized high raises cmp_en for that pin; for pin 2 it also raises cnt_en. The synchronized level appears SYNC_STAGES edges after the pad changes. A pin can never lower an enable: cmp_en is at least cmp_en_cfg and cnt_en is at least cnt_en_cfg.
- R6: In an input code, evt[i] is high for exactly one cycle when the synchronized level of pin i rises. A falling level produces no pulse.
- R7: dbg_req equals the synchronized level of pin 0 while pin 0 has code 11. It is 0 under every other code, including code 10.
- R8: When pad_in[0] is held high through reset for at least SYNC_STAGES cycles, dbg_req is already 1 in the first cycle after reset is released.
- R9: wake_req is 1 exactly when dbg_req is 1 and core_stopped is 1.
- R10: The reserved codes are pin 2 codes 01 and 10, pin 1 code 10, and pin 0 code 01. Under a reserved code the pin has pad_oe at 0. It contributes nothing to cmp_en, cnt_en, evt or dbg_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 6 | Mode register write data |
| cmp_hit | input | 3 | Detection pulse from comparator i |
| cmp_en_cfg | input | 3 | Register enable bit of comparator i |
| cnt_en_cfg | input | 1 | Register enable bit of the event counter |
| core_in_debug | input | 1 | Core is in debug state |
| core_single_step | input | 1 | Core is single-stepping |
| core_stopped | input | 1 | Core is in stop or wait state |
| pad_in | input | 3 | Sampled pin levels |
| pad_out | output | 3 | Pin drive values |
| pad_oe | output | 3 | Pin output enables |
| cmp_en | output | 3 | Effective comparator enables |
| cnt_en | output | 1 | Effective event counter enable |
| evt | output | 3 | Debug event pulse per pin |
| dbg_req | output | 1 | Debug entry request |
| wake_req | output | 1 | Request to leave stop or wait |

## Verification
The hardest situation to reach is a debug request that is already present when reset lifts. It depends on the synchronizer sampling pad_in while rst_n is still low, and on pin 0's reset code. The stimulus holds pad_in[0] high from time zero through several reset cycles and inspects dbg_req right after release. A second hard case is the acknowledge level frozen during single-step. There the stimulus changes core_in_debug in the same cycle that single-step rises, and confirms that pad_out[1] ignores it. Reserved codes are reached by writing mixed codes and then driving every pad high.

// File: rtl/evpin_pkg.sv
package evpin_pkg;
   localparam int unsigned PIN_COUNT = 3;
   localparam int unsigned MODE_W    = 2;
   localparam int unsigned CFG_W     = PIN_COUNT * MODE_W;
   localparam logic [CFG_W-1:0] CFG_RESET = CFG_W'(3);

   typedef enum logic [2:0] {
      ROLE_NONE,
      ROLE_DET_OUT,
      ROLE_ACK_OUT,
      ROLE_IN_EN,
      ROLE_IN_REQ
   } pin_role_e;

   // Per-pin code meaning; each pin has its own set of legal codes.
   function automatic pin_role_e decode_role(input int unsigned pin, input logic [MODE_W-1:0] code);
      pin_role_e r;
      case (code)
         2'b00:   r = ROLE_DET_OUT;
         2'b01:   r = (pin == 1) ? ROLE_ACK_OUT : ROLE_NONE;
         2'b10:   r = (pin == 0) ? ROLE_IN_EN   : ROLE_NONE;
         default: r = (pin == 0) ? ROLE_IN_REQ  : ROLE_IN_EN;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/evpin_sync.sv
module evpin_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("evpin_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("evpin_sync: WIDTH must be at least 1");
   end

   // No reset: the chain keeps sampling while reset is held.
   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) chain[s] <= d;
      end else begin : g_next
         always_ff @(posedge clk) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/evpin_lane.sv
module evpin_lane
   import evpin_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  pin_role_e role,
   input  logic      hit,
   input  logic      ack_lvl,
   input  logic      sync_lvl,
   output logic      pad_out,
   output logic      pad_oe,
   output logic      active,
   output logic      evt
);
   logic tog_q;
   logic prev_q;
   logic is_input;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             tog_q <= 1'b0;
      else if (role == ROLE_DET_OUT && hit)   tog_q <= ~tog_q;
   end

   // Edge history tracks the synchronized level even in reset,
   // so a pin held high through reset yields no stray event.
   always_ff @(posedge clk) prev_q <= sync_lvl;

   assign is_input = (role == ROLE_IN_EN) || (role == ROLE_IN_REQ);
   assign active   = is_input & sync_lvl;
   assign evt      = active & ~prev_q;
   assign pad_oe   = (role == ROLE_DET_OUT) || (role == ROLE_ACK_OUT);
   assign pad_out  = (role == ROLE_ACK_OUT) ? ack_lvl : tog_q;

   assert_reserved_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (role == ROLE_NONE) |-> (!pad_oe && !active && !evt));

   assert_evt_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> !evt);
endmodule

// File: rtl/evpin_ctrl.sv
module evpin_ctrl
   import evpin_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [CFG_W-1:0]     cfg_wdata,
   input  logic [PIN_COUNT-1:0] cmp_hit,
   input  logic [PIN_COUNT-1:0] cmp_en_cfg,
   input  logic                 cnt_en_cfg,
   input  logic                 core_in_debug,
   input  logic                 core_single_step,
   input  logic                 core_stopped,
   input  logic [PIN_COUNT-1:0] pad_in,
   output logic [PIN_COUNT-1:0] pad_out,
   output logic [PIN_COUNT-1:0] pad_oe,
   output logic [PIN_COUNT-1:0] cmp_en,
   output logic                 cnt_en,
   output logic [PIN_COUNT-1:0] evt,
   output logic                 dbg_req,
   output logic                 wake_req
);
   localparam int unsigned REQ_PIN = 0;
   localparam int unsigned ACK_PIN = 1;
   localparam int unsigned CNT_PIN = 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("evpin_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [CFG_W-1:0]     cfg_q;
   logic                 ack_q;
   logic [PIN_COUNT-1:0] pin_sync;
   logic [PIN_COUNT-1:0] pin_active;
   pin_role_e            role [PIN_COUNT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= CFG_RESET;
      else if (cfg_we) cfg_q <= cfg_wdata;
   end

   // Acknowledge level freezes while the core single-steps.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ack_q <= 1'b0;
      else if (!core_single_step) ack_q <= core_in_debug;
   end

   evpin_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .d   (pad_in),
      .q   (pin_sync)
   );

   for (genvar i = 0; i < PIN_COUNT; i++) begin : g_lane
      assign role[i] = decode_role(i, cfg_q[i*MODE_W +: MODE_W]);

      evpin_lane u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .role     (role[i]),
         .hit      (cmp_hit[i]),
         .ack_lvl  (ack_q),
         .sync_lvl (pin_sync[i]),
         .pad_out  (pad_out[i]),
         .pad_oe   (pad_oe[i]),
         .active   (pin_active[i]),
         .evt      (evt[i])
      );

      assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (role[i] == ROLE_DET_OUT && cmp_hit[i] && !cfg_we) |=> (pad_out[i] != $past(pad_out[i])));
   end

   assign cmp_en   = cmp_en_cfg | pin_active;
   assign cnt_en   = cnt_en_cfg | pin_active[CNT_PIN];
   assign dbg_req  = (role[REQ_PIN] == ROLE_IN_REQ) & pin_sync[REQ_PIN];
   assign wake_req = dbg_req & core_stopped;

   assert_enable_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmp_en & cmp_en_cfg) == cmp_en_cfg) && (cnt_en_cfg -> cnt_en));

   assert_ack_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (role[ACK_PIN] == ROLE_ACK_OUT && core_single_step && !cfg_we) |=> $stable(pad_out[ACK_PIN]));

   assert_req_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_req |-> (cfg_q[REQ_PIN*MODE_W +: MODE_W] == 2'b11));

   assert_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> (dbg_req && core_stopped));
endmodule

// File: tb/tb_evpin_ctrl.sv
`timescale 1ns/1ps
module tb_evpin_ctrl;
   typedef enum int {K_OUT, K_OE, K_CMP, K_CNT, K_EVT, K_REQ, K_WAKE} kind_e;
   typedef struct {
      string      req;
      kind_e      kind;
      logic [2:0] exp;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [5:0] cfg_wdata = '0;
   logic [2:0] cmp_hit = '0;
   logic [2:0] cmp_en_cfg = '0;
   logic       cnt_en_cfg = 1'b0;
   logic       core_in_debug = 1'b0;
   logic       core_single_step = 1'b0;
   logic       core_stopped = 1'b0;
   logic [2:0] pad_in = 3'b001;
   logic [2:0] pad_out, pad_oe, cmp_en, evt;
   logic       cnt_en, dbg_req, wake_req;

   int    n_run = 0;
   int    n_fail = 0;
   bit    done = 0;
   item_t sb_q[$];
   event  chk_ev;

   always #2.5 clk = ~clk;

   evpin_ctrl #(.SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cmp_hit(cmp_hit), .cmp_en_cfg(cmp_en_cfg), .cnt_en_cfg(cnt_en_cfg),
      .core_in_debug(core_in_debug), .core_single_step(core_single_step),
      .core_stopped(core_stopped), .pad_in(pad_in), .pad_out(pad_out),
      .pad_oe(pad_oe), .cmp_en(cmp_en), .cnt_en(cnt_en), .evt(evt),
      .dbg_req(dbg_req), .wake_req(wake_req)
   );

   function automatic logic [2:0] observe(kind_e k);
      case (k)
         K_OUT:   return pad_out;
         K_OE:    return pad_oe;
         K_CMP:   return cmp_en;
         K_CNT:   return {2'b00, cnt_en};
         K_EVT:   return evt;
         K_REQ:   return {2'b00, dbg_req};
         default: return {2'b00, wake_req};
      endcase
   endfunction

   // Monitor: pops expected items and compares with the live outputs.
   initial begin
      forever begin
         @(chk_ev);
         while (sb_q.size() > 0) begin
            item_t it;
            logic [2:0] act;
            it  = sb_q.pop_front();
            act = observe(it.kind);
            n_run++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s %s actual=%b expected=%b", it.req, it.kind.name(), act, it.exp);
            end
         end
      end
   end

   task automatic expect_now(string req, kind_e k, logic [2:0] e);
      item_t it;
      it.req = req; it.kind = k; it.exp = e;
      sb_q.push_back(it);
   endtask

   task automatic commit();
      #0.1;
      -> chk_ev;
      #0.1;
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_cfg(logic [5:0] v);
      cfg_we = 1'b1; cfg_wdata = v;
      tick(1);
      cfg_we = 1'b0;
   endtask

   task automatic pulse_hit(logic [2:0] h);
      cmp_hit = h;
      tick(1);
      cmp_hit = '0;
   endtask

   initial begin
      #500000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      tick(4);
      expect_now("R8 during reset", K_REQ, 3'b001); commit();
      rst_n = 1'b1;
      commit();
      expect_now("R8 after release", K_REQ, 3'b001);
      expect_now("R1 oe", K_OE, 3'b110);
      expect_now("R1 out", K_OUT, 3'b000);
      expect_now("R5 pin0 enable", K_CMP, 3'b001);
      expect_now("R6 no event from reset", K_EVT, 3'b000);
      commit();
      pad_in = 3'b000; tick(2);
      expect_now("R7 level follows", K_REQ, 3'b000); commit();

      // Detection toggles
      pulse_hit(3'b100);
      expect_now("R3 pin2 toggle", K_OUT, 3'b100); commit();
      pulse_hit(3'b110);
      expect_now("R3 pin1/pin2 toggle", K_OUT, 3'b010); commit();
      pulse_hit(3'b001);
      expect_now("R3 pin0 input ignores hit", K_OUT, 3'b010); commit();
      write_cfg(6'b000000);
      expect_now("R2 all detect oe", K_OE, 3'b111); commit();
      pulse_hit(3'b001);
      expect_now("R3 pin0 toggle", K_OUT, 3'b011); commit();

      // Acknowledge
      write_cfg(6'b000100);
      expect_now("R4 ack low", K_OUT, 3'b001);
      expect_now("R4 ack oe", K_OE, 3'b111); commit();
      core_in_debug = 1'b1; tick(1);
      expect_now("R4 ack follows", K_OUT, 3'b011); commit();
      core_single_step = 1'b1; core_in_debug = 1'b0; tick(2);
      expect_now("R4 ack frozen", K_OUT, 3'b011); commit();
      core_single_step = 1'b0; tick(1);
      expect_now("R4 ack resumes", K_OUT, 3'b001); commit();

      // Debug request and wake
      write_cfg(6'b000011);
      pad_in = 3'b001; tick(2);
      expect_now("R7 request", K_REQ, 3'b001);
      expect_now("R6 pin0 event", K_EVT, 3'b001);
      expect_now("R9 no wake when running", K_WAKE, 3'b000); commit();
      tick(1);
      expect_now("R6 pulse ends", K_EVT, 3'b000); commit();
      core_stopped = 1'b1;
      expect_now("R9 wake", K_WAKE, 3'b001); commit();
      core_stopped = 1'b0; pad_in = 3'b000; tick(2);
      expect_now("R7 request drops", K_REQ, 3'b000); commit();

      // Pin 0 plain input
      write_cfg(6'b000010);
      pad_in = 3'b001; tick(2);
      expect_now("R7 code10 no request", K_REQ, 3'b000);
      expect_now("R5 pin0 code10 enable", K_CMP, 3'b001);
      expect_now("R6 pin0 code10 event", K_EVT, 3'b001); commit();
      tick(1);
      expect_now("R6 single cycle", K_EVT, 3'b000); commit();
      pad_in = 3'b000; tick(2);
      expect_now("R5 enable follows", K_CMP, 3'b000);
      expect_now("R6 no falling event", K_EVT, 3'b000); commit();

      // Pin 2 input
      write_cfg(6'b110000);
      pad_in = 3'b100; tick(1);
      expect_now("R5 latency not yet", K_CMP, 3'b000); commit();
      tick(1);
      expect_now("R5 pin2 cmp", K_CMP, 3'b100);
      expect_now("R5 pin2 counter", K_CNT, 3'b001);
      expect_now("R6 pin2 event", K_EVT, 3'b100); commit();
      pad_in = 3'b000; cmp_en_cfg = 3'b100; cnt_en_cfg = 1'b1; tick(2);
      expect_now("R5 cannot disable cmp", K_CMP, 3'b100);
      expect_now("R5 cannot disable counter", K_CNT, 3'b001); commit();
      cmp_en_cfg = '0; cnt_en_cfg = 1'b0;
      expect_now("R5 both low", K_CMP, 3'b000); commit();

      // Pin 1 input
      write_cfg(6'b001100);
      pad_in = 3'b010; tick(2);
      expect_now("R6 pin1 event", K_EVT, 3'b010);
      expect_now("R5 pin1 cmp", K_CMP, 3'b010);
      expect_now("R5 pin1 no counter", K_CNT, 3'b000); commit();
      pad_in = 3'b000; tick(2);

      // Reserved codes
      write_cfg(6'b011001);
      expect_now("R10 oe off", K_OE, 3'b000); commit();
      pad_in = 3'b111; tick(2);
      expect_now("R10 no event", K_EVT, 3'b000);
      expect_now("R10 no cmp", K_CMP, 3'b000);
      expect_now("R10 no counter", K_CNT, 3'b000);
      expect_now("R10 no request", K_REQ, 3'b000); commit();
      pad_in = 3'b000; tick(2);
      write_cfg(6'b100000);
      expect_now("R10 pin2 code10 oe", K_OE, 3'b011); commit();
      pulse_hit(3'b100);
      write_cfg(6'b000000);
      expect_now("R10 reserved keeps toggle", K_OUT, 3'b011); commit();

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule